// File: doc/BRIEF.md
# Strobed PCM Serial Port

This block is the digital serial edge of a single-channel voice path. It moves 8-bit companded samples in and out over a strobed serial link. An active-high frame strobe opens one 8-bit timeslot per frame. Both directions share that slot. Serial input bits are sampled on falling bit-clock edges and assembled into a receive byte for the decoder. A transmit byte from the encoder is shifted out on rising bit-clock edges, most significant bit first. The serial output is enabled only while the strobe is high, and a separate enable pin stands in for a three-state pad.

Each direction has its own mute. A muted path carries the negative-zero quiet code of the selected companding law. A 3-bit clock-speed code picks the transfer mode. The slow bit rates run asynchronously, with a one-byte frame buffer in each direction, so samples arrive one frame late. All other rates run synchronously, with no frame delay. The serial bit clock, strobe and data are sampled in the fast system clock domain through a pipeline of configurable depth. Both edges of the bit clock are found there.

Top module: `pcm_strobe_port`

## Requirements
- R1: A slot opens when the strobe rises. The transmit byte is sent most significant bit first. After the (k+1)-th rising bit-clock edge of the slot, `dout_o` carries bit 7-k.
- R2: While the strobe is high, `din_i` is sampled on each falling bit-clock edge, most significant bit first. On the eighth sample, `rx_valid_o` pulses high for exactly one clock cycle, and `rx_data_o` holds the delivered byte.
- R3: `dout_oe_o` is 1 only while the strobe is high. Whenever `dout_oe_o` is 0, `dout_o` is 0.
- R4: If `tx_mute_i` is 1 when the strobe rises, that slot transmits the quiet code in place of the data.
- R5: If `rx_mute_i` is 1 when a byte is delivered, `rx_data_o` shows the quiet code in place of the received data.
- R6: `law_i` = 1 selects A-law, with quiet code 8'h55. `law_i` = 0 selects mu-law, with quiet code 8'h7F.
- R7: `csl_i` codes 3'b100 (128 kHz) and 3'b101 (256 kHz) select asynchronous mode. Codes 3'b000, 3'b001, 3'b010 and 3'b011 (512, 1536, 2048 and 4096 kHz) select synchronous mode. The reserved codes 3'b110 and 3'b111 act as synchronous mode. The mode is taken when the strobe rises.
- R8: In synchronous mode there is no frame delay. The slot sends the `tx_data_i` captured when its strobe rose. The byte received in the slot is delivered at the end of that same slot.
- R9: In asynchronous mode there is a delay of one frame. A slot sends the byte captured at the previous asynchronous slot's strobe rise. It delivers the byte received in the previous asynchronous slot. Suppose no such byte exists, because of reset or because the previous slot was synchronous. Then the slot sends the quiet code and delivers nothing.
- R10: If the strobe falls before eight bits have been received, the partial byte is discarded and no valid pulse occurs. Falling edges after the eighth in a slot are ignored.
- R11: While `rst_n` is low, `dout_oe_o` and `rx_valid_o` stay 0 and no data moves. After reset, both frame buffers are empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than the bit clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bclk_i | input | 1 | Serial bit clock |
| stb_i | input | 1 | Active-high frame strobe marking the slot |
| din_i | input | 1 | Serial receive data |
| dout_o | output | 1 | Serial transmit data |
| dout_oe_o | output | 1 | Output enable for the transmit pad |
| csl_i | input | 3 | Clock-speed select code |
| law_i | input | 1 | Companding law: 1 = A-law, 0 = mu-law |
| tx_mute_i | input | 1 | Transmit mute |
| rx_mute_i | input | 1 | Receive mute |
| tx_data_i | input | 8 | Byte from the encoder path |
| rx_data_o | output | 8 | Byte to the decoder path |
| rx_valid_o | output | 1 | One-cycle pulse with each delivered byte |

## Verification
The bench builds the port with the default of two input sampling stages. Each bit-clock phase lasts four system clocks, which is long enough for every edge to pass the sampling pipeline before the next one arrives. At that depth, one sweep of vectors reaches all six rate codes and both reserved codes. The same sweep covers both laws and both mutes, and a chain of asynchronous slots in which buffer contents carry across frames. Directed slots add strobe truncation, buffer clearing on a switch to synchronous mode, and activity on the serial pins during reset.

// File: rtl/pcm_port_pkg.sv
package pcm_port_pkg;
  localparam int unsigned SAMPLE_W = 8;
  localparam logic [SAMPLE_W-1:0] QUIET_MU = 8'h7F;
  localparam logic [SAMPLE_W-1:0] QUIET_A  = 8'h55;

  typedef enum logic {XFER_SYNC = 1'b0, XFER_ASYNC = 1'b1} xfer_mode_e;

  function automatic logic [SAMPLE_W-1:0] quiet_code(input logic law_a);
    return law_a ? QUIET_A : QUIET_MU;
  endfunction

  function automatic xfer_mode_e decode_rate(input logic [2:0] code);
    case (code)
      3'b100, 3'b101: return XFER_ASYNC;
      default:        return XFER_SYNC;
    endcase
  endfunction
endpackage

// File: rtl/pcm_in_sync.sv
module pcm_in_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic bclk_i,
  input  logic stb_i,
  input  logic din_i,
  output logic bclk_rise,
  output logic bclk_fall,
  output logic stb_lvl,
  output logic stb_rise,
  output logic din_s
);
  logic [2:0] pipe [STAGES];
  logic       bclk_last;
  logic       stb_last;

  for (genvar g = 0; g < STAGES; g++) begin : g_stage
    if (g == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= {bclk_i, stb_i, din_i};
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pipe[g] <= '0;
        else        pipe[g] <= pipe[g-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bclk_last <= 1'b0;
      stb_last  <= 1'b0;
    end else begin
      bclk_last <= pipe[STAGES-1][2];
      stb_last  <= pipe[STAGES-1][1];
    end
  end

  assign stb_lvl   = pipe[STAGES-1][1];
  assign din_s     = pipe[STAGES-1][0];
  assign bclk_rise = pipe[STAGES-1][2] & ~bclk_last;
  assign bclk_fall = ~pipe[STAGES-1][2] & bclk_last;
  assign stb_rise  = pipe[STAGES-1][1] & ~stb_last;
endmodule

// File: rtl/pcm_rx_path.sv
module pcm_rx_path
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                bit_fall,
  input  logic                din,
  input  xfer_mode_e          mode,
  input  logic                law_a,
  input  logic                mute,
  output logic [SAMPLE_W-1:0] rx_data,
  output logic                rx_valid
);
  localparam int unsigned CNT_W = $clog2(SAMPLE_W + 1);

  logic [SAMPLE_W-2:0] shift_q, shift_n;
  logic [CNT_W-1:0]    cnt_q, cnt_n;
  logic [SAMPLE_W-1:0] hold_q, hold_n;
  logic                full_q, full_n;
  logic [SAMPLE_W-1:0] data_q, data_n;
  logic                valid_q, valid_n;
  logic [SAMPLE_W-1:0] byte_in;

  assign byte_in = {shift_q, din};

  always_comb begin
    shift_n = shift_q;
    cnt_n   = cnt_q;
    hold_n  = hold_q;
    full_n  = full_q;
    data_n  = data_q;
    valid_n = 1'b0;
    if (frame_start) begin
      cnt_n = '0;
      if (mode == XFER_SYNC) full_n = 1'b0;
    end else if (bit_fall && (cnt_q < CNT_W'(SAMPLE_W))) begin
      cnt_n   = cnt_q + 1'b1;
      shift_n = byte_in[SAMPLE_W-2:0];
      if (cnt_q == CNT_W'(SAMPLE_W - 1)) begin
        if (mode == XFER_SYNC) begin
          valid_n = 1'b1;
          data_n  = mute ? quiet_code(law_a) : byte_in;
        end else begin
          if (full_q) begin
            valid_n = 1'b1;
            data_n  = mute ? quiet_code(law_a) : hold_q;
          end
          hold_n = byte_in;
          full_n = 1'b1;
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      cnt_q   <= CNT_W'(SAMPLE_W);
      hold_q  <= '0;
      full_q  <= 1'b0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      shift_q <= shift_n;
      cnt_q   <= cnt_n;
      hold_q  <= hold_n;
      full_q  <= full_n;
      data_q  <= data_n;
      valid_q <= valid_n;
    end
  end

  assign rx_data  = data_q;
  assign rx_valid = valid_q;
endmodule

// File: rtl/pcm_tx_path.sv
module pcm_tx_path
  import pcm_port_pkg::*;
(
  input  logic                clk,
  input  logic                rst_n,
  input  logic                frame_start,
  input  logic                bit_rise,
  input  logic [SAMPLE_W-1:0] tx_data,
  input  xfer_mode_e          mode,
  input  logic                law_a,
  input  logic                mute,
  output logic                dout
);
  logic [SAMPLE_W-1:0] shift_q, shift_n;
  logic [SAMPLE_W-1:0] hold_q, hold_n;
  logic                full_q, full_n;
  logic                dout_q, dout_n;
  logic [SAMPLE_W-1:0] src;

  always_comb begin
    shift_n = shift_q;
    hold_n  = hold_q;
    full_n  = full_q;
    dout_n  = dout_q;
    src     = tx_data;
    if (frame_start) begin
      if (mode == XFER_ASYNC) begin
        src    = full_q ? hold_q : quiet_code(law_a);
        hold_n = tx_data;
        full_n = 1'b1;
      end else begin
        full_n = 1'b0;
      end
      shift_n = mute ? quiet_code(law_a) : src;
    end else if (bit_rise) begin
      dout_n  = shift_q[SAMPLE_W-1];
      shift_n = {shift_q[SAMPLE_W-2:0], 1'b0};
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      shift_q <= '0;
      hold_q  <= '0;
      full_q  <= 1'b0;
      dout_q  <= 1'b0;
    end else begin
      shift_q <= shift_n;
      hold_q  <= hold_n;
      full_q  <= full_n;
      dout_q  <= dout_n;
    end
  end

  assign dout = dout_q;
endmodule

// File: rtl/pcm_strobe_port.sv
module pcm_strobe_port
  import pcm_port_pkg::*;
#(
  parameter int unsigned IN_STAGES = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                bclk_i,
  input  logic                stb_i,
  input  logic                din_i,
  output logic                dout_o,
  output logic                dout_oe_o,
  input  logic [2:0]          csl_i,
  input  logic                law_i,
  input  logic                tx_mute_i,
  input  logic                rx_mute_i,
  input  logic [SAMPLE_W-1:0] tx_data_i,
  output logic [SAMPLE_W-1:0] rx_data_o,
  output logic                rx_valid_o
);
  logic       bclk_rise, bclk_fall, stb_lvl, stb_rise, din_s;
  logic       tx_bit;
  xfer_mode_e mode_q, mode_n, mode_eff;

  pcm_in_sync #(.STAGES(IN_STAGES)) u_sync (
    .clk       (clk),
    .rst_n     (rst_n),
    .bclk_i    (bclk_i),
    .stb_i     (stb_i),
    .din_i     (din_i),
    .bclk_rise (bclk_rise),
    .bclk_fall (bclk_fall),
    .stb_lvl   (stb_lvl),
    .stb_rise  (stb_rise),
    .din_s     (din_s)
  );

  always_comb begin
    mode_n   = mode_q;
    mode_eff = mode_q;
    if (stb_rise) begin
      mode_n   = decode_rate(csl_i);
      mode_eff = mode_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) mode_q <= XFER_SYNC;
    else        mode_q <= mode_n;
  end

  pcm_rx_path u_rx (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (stb_rise),
    .bit_fall    (bclk_fall & stb_lvl),
    .din         (din_s),
    .mode        (mode_eff),
    .law_a       (law_i),
    .mute        (rx_mute_i),
    .rx_data     (rx_data_o),
    .rx_valid    (rx_valid_o)
  );

  pcm_tx_path u_tx (
    .clk         (clk),
    .rst_n       (rst_n),
    .frame_start (stb_rise),
    .bit_rise    (bclk_rise & stb_lvl),
    .tx_data     (tx_data_i),
    .mode        (mode_eff),
    .law_a       (law_i),
    .mute        (tx_mute_i),
    .dout        (tx_bit)
  );

  assign dout_oe_o = stb_lvl;
  assign dout_o    = stb_lvl & tx_bit;
endmodule

// File: rtl/pcm_strobe_port_chk.sv
module pcm_strobe_port_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       dout,
  input logic       dout_oe,
  input logic       rx_valid,
  input logic [7:0] rx_data,
  input logic       rx_mute,
  input logic       law
);
  // R2
  rx_pulse_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R5
  rx_mute_mu_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(rx_mute) && !$past(law)) |-> (rx_data == 8'h7F));

  // R6
  rx_mute_alaw_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_valid && $past(rx_mute) && $past(law)) |-> (rx_data == 8'h55));

  // R3
  dout_idle_low_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !dout_oe |-> !dout);

  // R11
  reset_silent_chk: assert property (@(posedge clk)
    !rst_n |-> (!dout_oe && !rx_valid));
endmodule

bind pcm_strobe_port pcm_strobe_port_chk u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .dout     (dout_o),
  .dout_oe  (dout_oe_o),
  .rx_valid (rx_valid_o),
  .rx_data  (rx_data_o),
  .rx_mute  (rx_mute_i),
  .law      (law_i)
);

// File: tb/pcm_strobe_port_tb.sv
module pcm_strobe_port_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       bclk = 1'b0, stb = 1'b0, din = 1'b0;
  logic       dout, dout_oe, law = 1'b0, txm = 1'b0, rxm = 1'b0, rx_valid;
  logic [2:0] csl = 3'b000;
  logic [7:0] tx_data = 8'h00, rx_data;

  int n_chk = 0, n_fail = 0;
  int vcount = 0;
  logic [7:0] vdata = 8'h00;

  always #10 clk = ~clk;

  pcm_strobe_port u_dut (
    .clk(clk), .rst_n(rst_n), .bclk_i(bclk), .stb_i(stb), .din_i(din),
    .dout_o(dout), .dout_oe_o(dout_oe), .csl_i(csl), .law_i(law),
    .tx_mute_i(txm), .rx_mute_i(rxm), .tx_data_i(tx_data),
    .rx_data_o(rx_data), .rx_valid_o(rx_valid)
  );

  always @(posedge clk) if (rx_valid) begin
    vcount <= vcount + 1;
    vdata  <= rx_data;
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wait_clk(input int n);
    repeat (n) @(negedge clk);
  endtask

  // Runs one slot with nbits bit-clock periods; returns serial byte seen on dout
  task automatic run_slot(input logic [7:0] rx_byte, input int nbits, output logic [7:0] seen, output logic oe_ok);
    seen  = 8'h00;
    oe_ok = 1'b1;
    @(negedge clk);
    bclk = 1'b0;
    stb  = 1'b1;
    wait_clk(4);
    for (int i = 0; i < nbits; i++) begin
      bclk = 1'b1;
      din  = rx_byte[7-i];
      wait_clk(4);
      seen[7-i] = dout;
      if (dout_oe !== 1'b1) oe_ok = 1'b0;
      bclk = 1'b0;
      wait_clk(4);
    end
    stb = 1'b0;
    wait_clk(8);
  endtask

  // vector: {csl[2:0], law, txm, rxm, tx[7:0], din[7:0]}
  localparam int NV = 11;
  localparam logic [21:0] VEC [NV] = '{
    {3'b000, 1'b0, 1'b0, 1'b0, 8'hA5, 8'h3C},
    {3'b001, 1'b1, 1'b0, 1'b0, 8'h5A, 8'hC3},
    {3'b010, 1'b0, 1'b1, 1'b0, 8'h12, 8'h34},
    {3'b011, 1'b1, 1'b0, 1'b1, 8'h9E, 8'hE1},
    {3'b110, 1'b0, 1'b0, 1'b0, 8'hF0, 8'h0F},
    {3'b100, 1'b0, 1'b0, 1'b0, 8'h11, 8'h22},
    {3'b101, 1'b1, 1'b0, 1'b0, 8'h33, 8'h44},
    {3'b100, 1'b0, 1'b0, 1'b1, 8'h55, 8'h66},
    {3'b100, 1'b1, 1'b1, 1'b0, 8'h77, 8'h88},
    {3'b111, 1'b0, 1'b0, 1'b0, 8'h99, 8'hAA},
    {3'b100, 1'b0, 1'b0, 1'b0, 8'hBB, 8'hCC}
  };

  function automatic logic [7:0] qc(input logic a);
    return a ? 8'h55 : 8'h7F;
  endfunction

  logic [7:0] m_tbuf = 8'h00, m_rbuf = 8'h00;
  logic       m_tfull = 1'b0, m_rfull = 1'b0;
  bit         done = 1'b0;

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin : main
    logic [7:0] seen, exp_tx, exp_rx;
    logic       oe_ok, exp_v, is_async;
    int         vc0;

    // R11 reset state
    wait_clk(3);
    check("R11 oe in reset", dout_oe, 1'b0);
    check("R11 valid in reset", rx_valid, 1'b0);
    rst_n = 1'b1;
    wait_clk(3);
    check("R3 oe idle", dout_oe, 1'b0);

    for (int v = 0; v < NV; v++) begin
      {csl, law, txm, rxm, tx_data} = VEC[v][21:8];
      is_async = (VEC[v][21:19] == 3'b100) || (VEC[v][21:19] == 3'b101);
      if (!is_async) begin
        // R8 zero delay, R7 incl. reserved codes
        exp_tx  = txm ? qc(law) : tx_data;
        exp_v   = 1'b1;
        exp_rx  = rxm ? qc(law) : VEC[v][7:0];
        m_tfull = 1'b0;
        m_rfull = 1'b0;
      end else begin
        // R9 one-frame delay
        exp_tx  = txm ? qc(law) : (m_tfull ? m_tbuf : qc(law));
        m_tbuf  = tx_data;
        m_tfull = 1'b1;
        exp_v   = m_rfull;
        exp_rx  = rxm ? qc(law) : m_rbuf;
        m_rbuf  = VEC[v][7:0];
        m_rfull = 1'b1;
      end
      vc0 = vcount;
      run_slot(VEC[v][7:0], 8, seen, oe_ok);
      // R1 MSB-first transmit, R4 tx mute, R6 law codes
      check($sformatf("R1/R4 tx byte vec%0d", v), seen, exp_tx);
      check($sformatf("R3 oe in slot vec%0d", v), oe_ok, 1'b1);
      check($sformatf("R3 oe after slot vec%0d", v), dout_oe, 1'b0);
      // R2 receive, R5 rx mute
      check($sformatf("R2 rx count vec%0d", v), vcount - vc0, exp_v ? 1 : 0);
      if (exp_v) check($sformatf("R5 rx data vec%0d", v), vdata, exp_rx);
    end

    // R10 truncated slot: 5 bits only, no delivery
    csl = 3'b000; law = 1'b0; txm = 1'b0; rxm = 1'b0; tx_data = 8'hC6;
    vc0 = vcount;
    run_slot(8'hB7, 5, seen, oe_ok);
    check("R10 truncated no valid", vcount - vc0, 0);
    check("R10 truncated tx prefix", seen[7:3], 5'b11000);

    // R10 next full slot unaffected by leftover partial bits
    tx_data = 8'h3A;
    vc0 = vcount;
    run_slot(8'h5D, 8, seen, oe_ok);
    check("R10 full after truncation", vcount - vc0, 1);
    check("R10 data after truncation", vdata, 8'h5D);
    check("R8 tx after truncation", seen, 8'h3A);

    // async slot to fill buffers, then reset clears them
    csl = 3'b101; tx_data = 8'hE7;
    run_slot(8'h18, 8, seen, oe_ok);
    check("R9 first async quiet", seen, 8'h7F);

    // R11 activity during reset
    @(negedge clk);
    rst_n = 1'b0;
    vc0 = vcount;
    stb = 1'b1;
    for (int i = 0; i < 8; i++) begin
      bclk = 1'b1; wait_clk(4);
      if (i == 3) check("R11 oe held off", dout_oe, 1'b0);
      bclk = 1'b0; wait_clk(4);
    end
    stb = 1'b0;
    wait_clk(4);
    check("R11 no valid during reset", vcount - vc0, 0);
    rst_n = 1'b1;
    wait_clk(4);

    // R11 buffers empty after reset: async slot sends quiet, delivers nothing
    csl = 3'b100; law = 1'b1; tx_data = 8'h42;
    vc0 = vcount;
    run_slot(8'h24, 8, seen, oe_ok);
    check("R11 async after reset tx quiet", seen, 8'h55);
    check("R11 async after reset no rx", vcount - vc0, 0);

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule